// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built from identical 4-bit slices. On each rising clock edge it clears to zero, loads a parallel word, advances by one, or keeps its value. Clear and load act on the clock edge only. Clear outranks load, and load outranks counting. Neither clear nor load looks at the count enables.

Counting needs two enables. The first, `enable_p`, goes to every slice. The second, `enable_t`, is the carry-style enable, and it also gates the terminal-count output. Inside the block, the terminal count of each slice drives the carry-style enable of the slice above it. The chained slices therefore count in plain binary across the whole width, with no added latency. The top-level `tc` can then drive a further instance of the block.

A chip-level asynchronous reset clears the state. Its release is synchronised to the clock before the counter sees it. A shorter count cycle can be made outside the block by decoding a chosen value and driving `clear_n` low from it.

Top module: `bcnt_chain`

## Requirements
- R1: While `rst_n` is low, `q` is 0. After `rst_n` rises, `q` stays 0 until a clear, load or count takes effect.
- R2: If `clear_n` is low at a rising edge, `q` becomes 0. This holds whatever the levels of `load_n`, `enable_p` and `enable_t`.
- R3: If `clear_n` is high and `load_n` is low at a rising edge, `q` takes the value of `d`. This holds whatever the levels of both enables.
- R4: If `clear_n`, `load_n`, `enable_p` and `enable_t` are all high at a rising edge, `q` increases by one modulo 2^W. The all-ones value wraps to 0.
- R5: If `clear_n` and `load_n` are high and either enable is low at a rising edge, `q` keeps its value.
- R6: `tc` is combinational. It is 1 exactly when `enable_t` is 1 and `q` is all ones, and it is 0 whenever `enable_t` is 0.
- R7: A carry out of a lower slice reaches the next slice on the same edge. For example, 0x0F counts to 0x10 in a single edge.
- R8: Driving `clear_n` low when `q` equals K makes the counter cycle through 0..K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low chip reset; release is synchronised inside the block |
| clear_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| enable_p | input | 1 | Count enable shared by all slices |
| enable_t | input | 1 | Carry-style count enable; also gates `tc` |
| d | input | W | Parallel load data (W = SLICE_W*STAGES, 8 by default) |
| q | output | W | Counter value |
| tc | output | 1 | Terminal count: `enable_t` and `q` all ones |

## Verification
Clear and load can both be active on the same edge. Either of them can also coincide with both enables being high. The random stimulus pulls `clear_n` and `load_n` low independently while the enables are mostly high, and directed steps force the clear-over-load case with new data on `d`. The bench model applies the fixed priority clear, then load, then count, then hold. Each `q` is compared against that model one edge later. A second overlap happens when a count edge is also a slice carry. This case is judged by checking the whole-width value, so a late carry into the upper slice would show up as a mismatch.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_r[STAGES-1];

  // R1
  release_after_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> $past(rst_n));
endmodule

// File: rtl/cnt_op_dec.sv
module cnt_op_dec import cnt_pkg::*; (
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!ld_n)        op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice import cnt_pkg::*; #(
  parameter int SLICE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic               en_p,
  input  logic               en_t,
  input  logic [SLICE_W-1:0] d,
  output logic [SLICE_W-1:0] q,
  output logic               tc
);
  cnt_op_e            op;
  logic [SLICE_W-1:0] q_r;
  logic [SLICE_W-1:0] q_nxt;
  logic               q_upd;

  cnt_op_dec u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  always_comb begin
    q_upd = (op != OP_HOLD);
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q_r + 1'b1;
      default:  q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (q_upd) q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = en_t & (&q_r);

  // R2
  slice_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));
  // R3
  slice_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (q == $past(d)));
  // R4
  slice_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t) |=> (q == SLICE_W'($past(q) + 1'b1)));
  // R5
  slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/bcnt_chain.sv
module bcnt_chain #(
  parameter int SLICE_W = 4,
  parameter int STAGES  = 2,
  parameter int SYNC_FF = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_n,
  input  logic                      load_n,
  input  logic                      enable_p,
  input  logic                      enable_t,
  input  logic [SLICE_W*STAGES-1:0] d,
  output logic [SLICE_W*STAGES-1:0] q,
  output logic                      tc
);
  localparam int W = SLICE_W * STAGES;

  logic              rst_sync_n;
  logic [STAGES:0]   carry;

  cnt_rst_sync #(.STAGES(SYNC_FF)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign carry[0] = enable_t;

  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    cnt_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr_n (clear_n),
      .ld_n  (load_n),
      .en_p  (enable_p),
      .en_t  (carry[k]),
      .d     (d[k*SLICE_W +: SLICE_W]),
      .q     (q[k*SLICE_W +: SLICE_W]),
      .tc    (carry[k+1])
    );
  end

  assign tc = carry[STAGES];

  // R6
  tc_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tc == (enable_t && (q == {W{1'b1}})));
  // R7
  wide_count_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clear_n && load_n && enable_p && enable_t) |=> (q == W'($past(q) + 1'b1)));
  // R5
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clear_n && load_n && !(enable_p && enable_t)) |=> $stable(q));
endmodule

// File: tb/bcnt_chain_test.sv
module bcnt_chain_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clear_n, load_n, enable_p, enable_t;
  logic [W-1:0] d;
  logic [W-1:0] q;
  logic         tc;

  int unsigned  n_cmp  = 0;
  int unsigned  n_bad  = 0;
  bit           done   = 1'b0;
  logic [W-1:0] mq;

  always #10 clk = ~clk;

  bcnt_chain uut (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
    .enable_p(enable_p), .enable_t(enable_t), .d(d), .q(q), .tc(tc)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c, logic l,
                                              logic p, logic t, logic [W-1:0] din);
    if (!c)          return '0;
    else if (!l)     return din;
    else if (p && t) return cur + 1'b1;
    else             return cur;
  endfunction

  function automatic logic model_tc(logic [W-1:0] cur, logic t);
    return t && (cur == {W{1'b1}});
  endfunction

  function automatic string tag_of(logic [W-1:0] cur, logic c, logic l, logic p, logic t);
    if (!c)      return "R2";
    else if (!l) return "R3";
    else if (p && t) return (cur[3:0] == 4'hF) ? "R7" : "R4";
    else         return "R5";
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, check tc, step, check q
  task automatic cycle(logic c, logic l, logic p, logic t, logic [W-1:0] din, string force_tag);
    string tg;
    @(negedge clk);
    clear_n = c; load_n = l; enable_p = p; enable_t = t; d = din;
    #2;
    check("R6", {{(W-1){1'b0}}, tc}, {{(W-1){1'b0}}, model_tc(mq, t)});
    tg = (force_tag != "") ? force_tag : tag_of(mq, c, l, p, t);
    @(posedge clk);
    mq = model_next(mq, c, l, p, t, din);
    #2;
    check(tg, q, mq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clear_n = 1'b1; load_n = 1'b1; enable_p = 1'b0; enable_t = 1'b0; d = '0;
    mq = '0;
    repeat (3) @(posedge clk);
    #2 check("R1", q, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 check("R1", q, '0);

    // reference sequence: clear, preset, count through wrap, inhibit
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R2");
    cycle(1'b1, 1'b0, 1'b1, 1'b1, 8'hFC, "R3");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R4");
    check("R4", q, 8'h02);
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R5");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
    // tc at all ones, and masked by enable_t
    cycle(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R3");
    cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6");
    cycle(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, "R6");
    // clear beats load with enables high
    cycle(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, "R2");
    // carry between slices
    cycle(1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, "R3");
    cycle(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R7");
    check("R7", q, 8'h10);
    // modulus reduction: clear when q == 5
    cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R2");
    for (int i = 0; i < 20; i++)
      cycle((mq != 8'd5), 1'b1, 1'b1, 1'b1, 8'h00, "R8");

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic c, l, p, t;
      c = (($urandom % 16) != 0);
      l = (($urandom % 8) != 0);
      p = (($urandom % 4) != 0);
      t = (($urandom % 4) != 0);
      cycle(c, l, p, t, W'($urandom), "");
    end
    finish_run();
  end
endmodule